// File: doc/BRIEF.md
# Four-Port Wormhole Flit Switch Core

This block moves flits through one node of a ring-style on-chip network that has four ports: local, clockwise, counterclockwise and across. Each input port owns a storage slot for exactly one flit. An upstream sender may write into a slot only while it is empty, and the block signals that with a per-input acknowledge. A flit waiting in a slot raises a transfer request on the output that an external route computation selected for it. The flit moves only when the downstream side acknowledges that request, which it does when its own single-flit slot is empty. On that step the flit leaves the source slot and is taken by the receiver, so it advances exactly one hop.

The block uses wormhole switching. A packet is a header flit, then a count flit whose low bits give the number of data flits, then those data flits. When a header wins a free output, that output stays bound to the winning input until the last data flit has gone. Only then can another packet's header compete for it. Each output chooses among the headers waiting for it by rotating priority. After reset the order is local, clockwise, counterclockwise, across. Each time a header is served, the served port drops to the lowest place.

Top module: `rtr_xfer_core`

## Requirements
- R1: While the synchronous active-high reset is asserted, every input slot is emptied, all of `in_ack` reads 1, all of `out_rx` reads 0, and every output's priority order returns to local, clockwise, counterclockwise, across.
- R2: `in_ack[i]` is 1 exactly when slot i is empty. A flit presented with `in_valid[i]` while `in_ack[i]` is 1 is stored at the next rising edge, and `in_ack[i]` then reads 0.
- R3: `out_rx[o]` is 1 when the input currently selected for output o holds a flit, and `out_flit[o]` carries that flit.
- R4: When `out_rx[o]` and `out_ack[o]` are both 1 at an edge, the selected input slot is emptied at that edge, and its `in_ack` reads 1 in the following cycle.
- R5: A request without an acknowledge changes nothing: the flit stays in its slot, `out_flit[o]` is unchanged and the request stays raised.
- R6: Port indices are local=0, clockwise=1, counterclockwise=2, across=3, and `route_sel` uses the same 2-bit codes, one field per input with input 0 in the low bits. Among inputs whose waiting header targets a free output, only the one highest in that output's current order is presented. The others keep their flits.
- R7: After a header transfers on an output, that output's priority order rotates so that the served input is lowest and the input after it is highest.
- R8: Once a header has transferred, its output serves only that input. Headers from other inputs wait, and no other input's flit is placed between that packet's flits.
- R9: The flit after the header carries the data-flit count N in its low CNT_W bits. The output is released after the Nth data flit transfers, or right after the count flit when N is 0.
- R10: Different outputs transfer in the same step independently, and each transfer empties a different input slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 4 | Per-input request from the upstream sender |
| in_flit | input | 4*FLIT_W | Incoming flits, input i in bits [i*FLIT_W +: FLIT_W] |
| in_ack | output | 4 | Per-input acknowledge, high while the slot is empty |
| route_sel | input | 8 | Output chosen for each input's waiting flit, 2 bits per input |
| out_rx | output | 4 | Per-output transfer request toward the downstream slot |
| out_flit | output | 4*FLIT_W | Flit presented on each output |
| out_ack | input | 4 | Downstream acknowledge, high while its slot is empty |

## Verification
The delicate case is the step where a locked output sends its last data flit. The release and the rotation happen on the same edge, and the next step must already present the header of a different waiting input, chosen by the rotated order. The bench provokes this by keeping other headers waiting for the same output while a packet with a count of 1 or 2 streams through. It checks that the request stays low while the owner's slot is empty mid-packet, and that the first flit shown after release belongs to the input just after the previous winner. A second overlap, two outputs transferring on one edge, is provoked by acknowledging both together and judged by both input slots reading empty on the next step.

// File: rtl/rtr_pkg.sv
package rtr_pkg;
   localparam int NP = 4;
   localparam int SW = $clog2(NP);

   typedef enum logic [1:0] {
      PT_LOC = 2'd0,
      PT_CW  = 2'd1,
      PT_CCW = 2'd2,
      PT_ACR = 2'd3
   } port_e;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_CNT  = 2'd1,
      PH_DATA = 2'd2
   } phase_e;
endpackage

// File: rtl/rtr_inbuf.sv
module rtr_inbuf #(
   parameter int FLIT_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic              take,
   input  logic [FLIT_W-1:0] din,
   output logic              full,
   output logic [FLIT_W-1:0] dout
);
   // one-place slot: refill only possible while empty, so take and load never collide
   always_ff @(posedge clk) begin
      if (rst) begin
         full <= 1'b0;
         dout <= '0;
      end else if (take) begin
         full <= 1'b0;
      end else if (load && !full) begin
         full <= 1'b1;
         dout <= din;
      end
   end
endmodule

// File: rtl/rtr_outport.sv
module rtr_outport
   import rtr_pkg::*;
#(
   parameter int FLIT_W = 16,
   parameter int CNT_W  = 8
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [NP-1:0]        cand,
   input  logic [NP-1:0]        full,
   input  logic [NP*FLIT_W-1:0] bufs,
   input  logic                 ack,
   output logic                 rx,
   output logic [FLIT_W-1:0]    flit,
   output logic [NP-1:0]        take,
   output logic                 lock,
   output logic [SW-1:0]        owner
);
   phase_e            ph;
   logic [SW-1:0]     ptr;
   logic [SW-1:0]     own_q;
   logic [CNT_W-1:0]  rem;
   logic [SW-1:0]     win;
   logic [SW-1:0]     idx;
   logic [SW-1:0]     src;
   logic              hit;
   logic              go;

   // rotating search starting at the highest-priority index
   always_comb begin
      win = '0;
      hit = 1'b0;
      idx = '0;
      for (int k = 0; k < NP; k++) begin
         idx = ptr + SW'(k);
         if (!hit && cand[idx]) begin
            hit = 1'b1;
            win = idx;
         end
      end
   end

   assign lock  = (ph != PH_IDLE);
   assign owner = own_q;
   assign src   = lock ? own_q : win;
   assign rx    = lock ? full[own_q] : hit;
   assign flit  = bufs[src*FLIT_W +: FLIT_W];
   assign go    = rx && ack;
   assign take  = go ? (NP'(1) << src) : '0;

   always_ff @(posedge clk) begin
      if (rst) begin
         ph    <= PH_IDLE;
         ptr   <= SW'(PT_LOC);
         own_q <= '0;
         rem   <= '0;
      end else if (go) begin
         case (ph)
            PH_IDLE: begin
               ph    <= PH_CNT;
               own_q <= win;
               ptr   <= win + SW'(1);
            end
            PH_CNT: begin
               if (flit[CNT_W-1:0] == '0) begin
                  ph <= PH_IDLE;
               end else begin
                  ph  <= PH_DATA;
                  rem <= flit[CNT_W-1:0];
               end
            end
            PH_DATA: begin
               if (rem == CNT_W'(1)) ph <= PH_IDLE;
               rem <= rem - CNT_W'(1);
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rtr_xfer_core.sv
module rtr_xfer_core
   import rtr_pkg::*;
#(
   parameter int FLIT_W = 16,
   parameter int CNT_W  = 8
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [NP-1:0]        in_valid,
   input  logic [NP*FLIT_W-1:0] in_flit,
   output logic [NP-1:0]        in_ack,
   input  logic [NP*SW-1:0]     route_sel,
   output logic [NP-1:0]        out_rx,
   output logic [NP*FLIT_W-1:0] out_flit,
   input  logic [NP-1:0]        out_ack
);
   if (CNT_W < 1 || CNT_W > FLIT_W) begin : g_bad_cnt
      $error("CNT_W must lie between 1 and FLIT_W");
   end
   if (NP != (1 << SW)) begin : g_bad_np
      $error("port count must be a power of two");
   end

   logic [NP-1:0]        full;
   logic [NP*FLIT_W-1:0] bufs;
   logic [NP-1:0]        bound;
   logic [NP-1:0]        in_take;
   logic [NP-1:0]        out_lock;
   logic [SW-1:0]        own [NP];
   logic [NP-1:0]        cand_m [NP];
   logic [NP-1:0]        take_m [NP];

   // an input already owning an output must not compete with a new header
   always_comb begin
      for (int i = 0; i < NP; i++) begin
         bound[i] = 1'b0;
         for (int o = 0; o < NP; o++)
            bound[i] = bound[i] | (out_lock[o] && own[o] == SW'(i));
      end
      for (int o = 0; o < NP; o++)
         for (int i = 0; i < NP; i++)
            cand_m[o][i] = full[i] && !bound[i] && (route_sel[i*SW +: SW] == SW'(o));
   end

   always_comb begin
      for (int i = 0; i < NP; i++) begin
         in_take[i] = 1'b0;
         for (int o = 0; o < NP; o++)
            in_take[i] = in_take[i] | take_m[o][i];
      end
   end

   assign in_ack = ~full;

   for (genvar i = 0; i < NP; i++) begin : g_in
      rtr_inbuf #(.FLIT_W(FLIT_W)) i_buf (
         .clk  (clk),
         .rst  (rst),
         .load (in_valid[i]),
         .take (in_take[i]),
         .din  (in_flit[i*FLIT_W +: FLIT_W]),
         .full (full[i]),
         .dout (bufs[i*FLIT_W +: FLIT_W])
      );
   end

   for (genvar o = 0; o < NP; o++) begin : g_out
      rtr_outport #(.FLIT_W(FLIT_W), .CNT_W(CNT_W)) i_port (
         .clk   (clk),
         .rst   (rst),
         .cand  (cand_m[o]),
         .full  (full),
         .bufs  (bufs),
         .ack   (out_ack[o]),
         .rx    (out_rx[o]),
         .flit  (out_flit[o*FLIT_W +: FLIT_W]),
         .take  (take_m[o]),
         .lock  (out_lock[o]),
         .owner (own[o])
      );
   end
endmodule

// File: rtl/rtr_xfer_chk.sv
module rtr_xfer_chk
   import rtr_pkg::*;
#(
   parameter int FLIT_W = 16
) (
   input logic                 clk,
   input logic                 rst,
   input logic [NP-1:0]        in_valid,
   input logic [NP-1:0]        in_ack,
   input logic [NP-1:0]        out_rx,
   input logic [NP-1:0]        out_ack,
   input logic [NP-1:0]        out_lock,
   input logic [NP-1:0]        in_take,
   input logic [NP*FLIT_W-1:0] out_flit
);
   logic rst_q;
   always_ff @(posedge clk) rst_q <= rst;

   always @(posedge clk) begin
      if (rst_q === 1'b1) begin
         AST_RESET_IDLE: assert (in_ack == '1 && out_rx == '0); // R1
      end
   end

   AST_XFER_COUNT: assert property (@(posedge clk) disable iff (rst)
      $countones(in_take) == $countones(out_rx & out_ack)); // R10

   for (genvar p = 0; p < NP; p++) begin : g_p
      AST_LOAD_FILLS: assert property (@(posedge clk) disable iff (rst)
         in_valid[p] && in_ack[p] |=> !in_ack[p]); // R2
      AST_TAKE_FREES: assert property (@(posedge clk) disable iff (rst)
         in_take[p] |=> in_ack[p]); // R4
      AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
         out_rx[p] && !out_ack[p] && out_lock[p] |=>
            out_rx[p] && $stable(out_flit[p*FLIT_W +: FLIT_W])); // R5
   end
endmodule

bind rtr_xfer_core rtr_xfer_chk #(.FLIT_W(FLIT_W)) i_rtr_xfer_chk (
   .clk      (clk),
   .rst      (rst),
   .in_valid (in_valid),
   .in_ack   (in_ack),
   .out_rx   (out_rx),
   .out_ack  (out_ack),
   .out_lock (out_lock),
   .in_take  (in_take),
   .out_flit (out_flit)
);

// File: tb/test_rtr_xfer_core.sv
module test_rtr_xfer_core;
   localparam int CLK_P  = 10;
   localparam int FLIT_W = 16;
   localparam int CNT_W  = 8;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic [3:0]     in_valid = '0;
   logic [63:0]    in_flit = '0;
   logic [3:0]     in_ack;
   logic [7:0]     route_sel = '0;
   logic [3:0]     out_rx;
   logic [63:0]    out_flit;
   logic [3:0]     out_ack = '0;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   rtr_xfer_core #(.FLIT_W(FLIT_W), .CNT_W(CNT_W)) i_rtr_xfer_core (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_flit(in_flit),
      .in_ack(in_ack), .route_sel(route_sel), .out_rx(out_rx),
      .out_flit(out_flit), .out_ack(out_ack)
   );

   always #(CLK_P/2) clk = ~clk;

   // fields: valid[23:20] route[19:12] ack[11:8] exp_rx[7:4] exp_in_ack[3:0]
   localparam logic [23:0] VEC [10] = '{
      24'h1_00_0_0_F, 24'h0_05_0_2_E, 24'h2_05_0_2_E, 24'h0_05_2_2_C,
      24'h1_05_0_0_D, 24'h0_05_2_2_C, 24'h1_05_0_0_D, 24'h0_05_2_2_C,
      24'h0_05_0_2_D, 24'h0_05_2_2_D
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic put(input int p, input logic [15:0] f);
      in_valid[p] = 1'b1;
      in_flit[p*16 +: 16] = f;
   endtask

   function automatic logic [15:0] fo(input int o);
      return out_flit[o*16 +: 16];
   endfunction

   task automatic do_reset();
      rst = 1'b1; in_valid = '0; out_ack = '0;
      cyc(); cyc();
      rst = 1'b0;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      cyc(); cyc();
      #1;
      chk("R1 reset in_ack", 32'(in_ack), 32'hF);
      chk("R1 reset out_rx", 32'(out_rx), 32'h0);
      rst = 1'b0;
      cyc();

      // table walk: header, count 1, one data flit, then waiting header wins
      in_flit = {4{16'h0001}};
      for (int r = 0; r < 10; r++) begin
         in_valid  = VEC[r][23:20];
         route_sel = VEC[r][19:12];
         out_ack   = VEC[r][11:8];
         #1;
         chk($sformatf("R3 R8 R9 table row %0d out_rx", r), 32'(out_rx), 32'(VEC[r][7:4]));
         chk($sformatf("R2 R4 table row %0d in_ack", r), 32'(in_ack), 32'(VEC[r][3:0]));
         cyc();
      end

      // priority, rotation and wormhole lock on the counterclockwise output
      do_reset();
      route_sel = 8'hAA;
      for (int i = 0; i < 4; i++) put(i, 16'hA000 + 16'(i) * 16'h0100);
      cyc();
      in_valid = '0; out_ack = 4'b0100; #1;
      chk("R3 request raised", 32'(out_rx[2]), 32'h1);
      chk("R6 local wins from reset order", 32'(fo(2)), 32'hA000);
      cyc();
      out_ack = '0; put(0, 16'h0000); #1;
      chk("R8 locked owner empty", 32'(out_rx[2]), 32'h0);
      chk("R4 source slot freed", 32'(in_ack), 32'h1);
      cyc();
      in_valid = '0; out_ack = 4'b0100; #1;
      chk("R8 count flit of owner", 32'(fo(2)), 32'h0000);
      cyc();
      out_ack = '0; put(0, 16'hA000); #1;
      chk("R7 R9 released after zero count, clockwise next", 32'(fo(2)), 32'hA100);
      cyc();
      in_valid = '0; #1;
      chk("R7 served local now lowest", 32'(fo(2)), 32'hA100);
      out_ack = 4'b0100;
      cyc();
      out_ack = '0; put(1, 16'h0002); #1;
      chk("R8 other headers wait", 32'(out_rx[2]), 32'h0);
      cyc();
      in_valid = '0; out_ack = 4'b0100; #1;
      chk("R9 count flit", 32'(fo(2)), 32'h0002);
      cyc();
      out_ack = '0; put(1, 16'hD001);
      cyc();
      in_valid = '0; out_ack = 4'b0100; #1;
      chk("R9 first data flit", 32'(fo(2)), 32'hD001);
      cyc();
      out_ack = '0; #1;
      chk("R9 still locked after one of two", 32'(out_rx[2]), 32'h0);
      put(1, 16'hD002);
      cyc();
      in_valid = '0; out_ack = 4'b0100; #1;
      chk("R9 second data flit", 32'(fo(2)), 32'hD002);
      cyc();
      out_ack = '0; #1;
      chk("R7 after release counterclockwise input first", 32'(fo(2)), 32'hA200);
      for (int k = 0; k < 3; k++) begin
         cyc(); #1;
         chk("R5 unacked flit held", 32'(fo(2)), 32'hA200);
         chk("R5 slot stays occupied", 32'(in_ack[2]), 32'h0);
      end
      cyc();

      // two outputs transfer on one edge
      do_reset();
      route_sel = 8'h01;
      put(0, 16'hB000); put(3, 16'hB300);
      cyc();
      in_valid = '0; out_ack = 4'b0011; #1;
      chk("R10 output cw shows local", 32'(fo(1)), 32'hB000);
      chk("R10 output local shows across", 32'(fo(0)), 32'hB300);
      cyc();
      out_ack = '0; #1;
      chk("R10 R4 both slots emptied", 32'(in_ack), 32'hF);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule